// File: doc/BRIEF.md
# Big-Endian Byte and Word Load-Store Unit

This unit sits between a processor core and a word-wide, byte-addressed data memory. For each request it adds the sign-extended immediate offset to the base register value to form the effective address. It then drives the word address, the per-byte write enables and the write data toward memory. A load's read data comes back from memory one cycle later. The unit then aligns that word, or one byte taken from it, into the destination register value.

Byte lanes are numbered in big-endian order: the lowest byte address within a word is the most significant byte. A byte store repeats the source byte on every lane and enables only one lane. A byte load picks one lane and sign-extends it. A word access whose effective address is not a multiple of the word size is flagged as misaligned in the cycle of the request, and no memory operation is issued for it.

Top module: `bel_lsu`

## Requirements
- R1: The effective address is `base + sign_extend(offset)`, where the offset may be negative. `mem_addr` carries the effective address with its two low bits removed.
- R2: Only `req_op` values 35 (word load), 43 (word store), 32 (byte load) and 40 (byte store) start an access, and only while `req_valid` is high. Any other value, or `req_valid` low, leaves `mem_re`, `mem_we` and `misalign` low and does not change memory.
- R3: Byte offset k (the effective address modulo 4) selects data bits [31-8k : 24-8k]. Bit i of `mem_we` enables data bits [8i+7 : 8i], so offset 0 maps to bit 3.
- R4: A byte store asserts exactly one enable, bit 3-k, and drives `store_data[7:0]` on all four lanes of `mem_wdata`. The other three bytes of that memory word keep their contents.
- R5: An aligned word store asserts all four enables and drives `store_data` unchanged on `mem_wdata`.
- R6: A byte load raises `ld_valid` in the cycle after the request. `ld_data` then holds the selected byte in bits 7:0, with bits 31:8 copies of its bit 7.
- R7: An issued load raises `mem_re` in the cycle of the request. In the following cycle `ld_valid` is high, and for a word load `ld_data` equals `mem_rdata`. `ld_valid` is never high unless `mem_re` was high in the cycle before.
- R8: A word access whose effective address bits 1:0 are not 00 raises `misalign` in the request cycle. It asserts no write enable and no `mem_re`, and raises no `ld_valid` in the next cycle. Byte accesses are never flagged.
- R9: During and straight after reset, `ld_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 6 | Operation code (32, 35, 40, 43) |
| base | input | ADDR_W | Base register value |
| offset | input | OFF_W | Signed immediate offset |
| store_data | input | DATA_W | Source register value for stores |
| mem_addr | output | ADDR_W-2 | Word address to memory |
| mem_re | output | 1 | Read strobe to memory |
| mem_we | output | DATA_W/8 | Per-byte write enables, bit i for bits 8i+7:8i |
| mem_wdata | output | DATA_W | Write data with lanes placed |
| misalign | output | 1 | Misaligned word access flag |
| mem_rdata | input | DATA_W | Read word, valid the cycle after mem_re |
| ld_valid | output | 1 | Load result present |
| ld_data | output | DATA_W | Aligned and extended load result |

## Verification
The assertions assume that memory returns the read word in exactly the cycle after `mem_re`. They also assume that `req_op` holds a known value whenever `req_valid` is high. The bench's memory model latches its read word on the edge after the strobe. The bench drives a defined opcode on every request, including the deliberately undefined codes. Requests are spaced two cycles apart, so a load response is never overlapped by a store to the same word. The bench's reference memory is therefore always current when a response is compared.

// File: rtl/bel_pkg.sv
package bel_pkg;

  typedef enum logic [5:0] {
    OPC_LB = 6'd32,
    OPC_LW = 6'd35,
    OPC_SB = 6'd40,
    OPC_SW = 6'd43
  } opc_e;

  typedef struct packed {
    logic acc;   // a defined access
    logic wr;    // store when set
    logic byt;   // byte size when set
  } acc_t;

  function automatic acc_t decode_op(input logic [5:0] op);
    acc_t a;
    a = '0;
    case (op)
      OPC_LB: begin a.acc = 1'b1; a.byt = 1'b1; end
      OPC_LW: begin a.acc = 1'b1; end
      OPC_SB: begin a.acc = 1'b1; a.wr = 1'b1; a.byt = 1'b1; end
      OPC_SW: begin a.acc = 1'b1; a.wr = 1'b1; end
      default: a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/bel_addr_gen.sv
module bel_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LANES  = 4,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0]       base,
  input  logic [OFF_W-1:0]        offset,
  output logic [ADDR_W-1:0]       eff_addr,
  output logic [ADDR_W-OFS_W-1:0] word_addr,
  output logic [OFS_W-1:0]        byte_ofs
);

  function automatic logic [ADDR_W-1:0] sext_off(input logic [OFF_W-1:0] o);
    return {{(ADDR_W-OFF_W){o[OFF_W-1]}}, o};
  endfunction

  always_comb begin
    eff_addr  = base + sext_off(offset);
    word_addr = eff_addr[ADDR_W-1:OFS_W];
    byte_ofs  = eff_addr[OFS_W-1:0];
  end

endmodule

// File: rtl/bel_store_lane.sv
module bel_store_lane #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DATA_W = LANES * BYTE_W,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic              do_wr,
  input  logic              is_byte,
  input  logic [OFS_W-1:0]  byte_ofs,
  input  logic [DATA_W-1:0] store_data,
  output logic [LANES-1:0]  we,
  output logic [DATA_W-1:0] wdata
);

  // Big-endian: byte offset 0 lives in the highest lane.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFS_W-1:0] OFS_HERE = OFS_W'(LANES - 1 - i);
    assign we[i] = do_wr & (~is_byte | (byte_ofs == OFS_HERE));
    assign wdata[i*BYTE_W +: BYTE_W] = is_byte ? store_data[BYTE_W-1:0]
                                               : store_data[i*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/bel_load_align.sv
module bel_load_align #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DATA_W = LANES * BYTE_W,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              is_byte,
  input  logic [OFS_W-1:0]  byte_ofs,
  input  logic [DATA_W-1:0] rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);

  logic             pend_q;
  logic             byt_q;
  logic [OFS_W-1:0] ofs_q;
  logic [BYTE_W-1:0] sel_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      byt_q  <= 1'b0;
      ofs_q  <= '0;
    end else begin
      pend_q <= issue;
      if (issue) begin
        byt_q <= is_byte;
        ofs_q <= byte_ofs;
      end
    end
  end

  function automatic logic [DATA_W-1:0] sext_byte(input logic [BYTE_W-1:0] b);
    return {{(DATA_W-BYTE_W){b[BYTE_W-1]}}, b};
  endfunction

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < LANES; i++) begin
      if (ofs_q == OFS_W'(LANES - 1 - i)) sel_byte = rdata[i*BYTE_W +: BYTE_W];
    end
    ld_valid = pend_q;
    ld_data  = byt_q ? sext_byte(sel_byte) : rdata;
  end

endmodule

// File: rtl/bel_lsu.sv
module bel_lsu #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DATA_W = LANES * BYTE_W,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [5:0]              req_op,
  input  logic [ADDR_W-1:0]       base,
  input  logic [OFF_W-1:0]        offset,
  input  logic [DATA_W-1:0]       store_data,
  output logic [ADDR_W-OFS_W-1:0] mem_addr,
  output logic                    mem_re,
  output logic [LANES-1:0]        mem_we,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic                    misalign,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    ld_valid,
  output logic [DATA_W-1:0]       ld_data
);
  import bel_pkg::*;

  acc_t             acc;
  logic [ADDR_W-1:0] eff_addr;
  logic [OFS_W-1:0]  byte_ofs;
  logic              live;      // defined access this cycle
  logic              rd_issue;  // load sent to memory
  logic              wr_issue;  // store sent to memory

  always_comb begin
    acc      = decode_op(req_op);
    live     = req_valid & acc.acc;
    misalign = live & ~acc.byt & (byte_ofs != '0);
    rd_issue = live & ~acc.wr & ~misalign;
    wr_issue = live &  acc.wr & ~misalign;
    mem_re   = rd_issue;
  end

  bel_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANES(LANES)) u_agen (
    .base      (base),
    .offset    (offset),
    .eff_addr  (eff_addr),
    .word_addr (mem_addr),
    .byte_ofs  (byte_ofs)
  );

  bel_store_lane #(.LANES(LANES), .BYTE_W(BYTE_W)) u_st (
    .do_wr      (wr_issue),
    .is_byte    (acc.byt),
    .byte_ofs   (byte_ofs),
    .store_data (store_data),
    .we         (mem_we),
    .wdata      (mem_wdata)
  );

  bel_load_align #(.LANES(LANES), .BYTE_W(BYTE_W)) u_ld (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (rd_issue),
    .is_byte  (acc.byt),
    .byte_ofs (byte_ofs),
    .rdata    (mem_rdata),
    .ld_valid (ld_valid),
    .ld_data  (ld_data)
  );

endmodule

// File: rtl/bel_lsu_checker.sv
module bel_lsu_checker #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DATA_W = LANES * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [5:0]        req_op,
  input logic              mem_re,
  input logic [LANES-1:0]  mem_we,
  input logic              misalign,
  input logic              ld_valid,
  input logic [DATA_W-1:0] ld_data
);
  import bel_pkg::*;

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (mem_we == '0 && !mem_re && !misalign));

  p_byte_store_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OPC_SB) |-> ($countones(mem_we) == 1 && !misalign));

  p_word_store_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OPC_SW && !misalign) |-> (&mem_we));

  p_byte_load_signext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && req_op == OPC_LB) |=>
      (ld_data[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){ld_data[BYTE_W-1]}}));

  p_load_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> ld_valid);

  p_no_stray_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_re |=> !ld_valid);

  p_misalign_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_we == '0 && !mem_re));

endmodule

bind bel_lsu bel_lsu_checker #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .mem_re    (mem_re),
  .mem_we    (mem_we),
  .misalign  (misalign),
  .ld_valid  (ld_valid),
  .ld_data   (ld_data)
);

// File: tb/test_bel_lsu.sv
module test_bel_lsu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_op = '0;
  logic [31:0] base = '0;
  logic [15:0] offset = '0;
  logic [31:0] store_data = '0;
  logic [29:0] mem_addr;
  logic        mem_re;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata;
  logic        misalign;
  logic [31:0] mem_rdata;
  logic        ld_valid;
  logic [31:0] ld_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] mdl [16];
  logic [31:0] ref_mem [16];
  logic [31:0] rd_q;

  always #5 clk = ~clk;

  bel_lsu i_bel_lsu (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .base(base), .offset(offset), .store_data(store_data),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .misalign(misalign), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  function automatic logic [31:0] init_word(input int w);
    return 32'h9A5C_3E71 ^ (32'(w) * 32'h1357_9BDF);
  endfunction

  // Memory model: read word appears one cycle after the strobe.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 16; w++) mdl[w] <= init_word(w);
      rd_q <= '0;
    end else begin
      if (mem_re) rd_q <= mdl[mem_addr[3:0]];
      for (int i = 0; i < 4; i++)
        if (mem_we[i]) mdl[mem_addr[3:0]][i*8 +: 8] <= mem_wdata[i*8 +: 8];
    end
  end
  assign mem_rdata = rd_q;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] op, input logic vld,
                       input logic [31:0] b, input logic [15:0] o,
                       input logic [31:0] sd);
    logic [31:0] ea;
    logic        known, is_wr, is_byt, mis, ld;
    logic [1:0]  k;
    logic [3:0]  exp_we;
    logic [31:0] w, exp_ld;
    logic [7:0]  bt;
    @(negedge clk);
    req_valid = vld; req_op = op; base = b; offset = o; store_data = sd;
    #1;
    ea     = b + {{16{o[15]}}, o};
    k      = ea[1:0];
    known  = vld && (op == 6'd32 || op == 6'd35 || op == 6'd40 || op == 6'd43);
    is_wr  = (op == 6'd40 || op == 6'd43);
    is_byt = (op == 6'd32 || op == 6'd40);
    mis    = known && !is_byt && (k != 2'd0);
    ld     = known && !is_wr && !mis;
    exp_we = (known && is_wr && !mis) ? (is_byt ? (4'b1000 >> k) : 4'hF) : 4'h0;
    chk("R8 misalign", {31'd0, misalign}, {31'd0, mis});
    chk("R2 read strobe", {31'd0, mem_re}, {31'd0, ld});
    chk("R4/R5 enables", {28'd0, mem_we}, {28'd0, exp_we});
    if (known && !mis) chk("R1 word address", {2'b0, mem_addr}, {2'b0, ea[31:2]});
    if (exp_we != 4'h0)
      chk(is_byt ? "R4 lane copies" : "R5 word data", mem_wdata,
          is_byt ? {4{sd[7:0]}} : sd);
    if (exp_we != 4'h0) begin
      if (is_byt) ref_mem[ea[5:2]][8*(3-k) +: 8] = sd[7:0];
      else        ref_mem[ea[5:2]] = sd;
    end
    w = ref_mem[ea[5:2]];
    bt = 8'(w >> (8 * (3 - k)));
    exp_ld = is_byt ? 32'($signed(bt)) : w;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R7 load valid", {31'd0, ld_valid}, {31'd0, ld});
    if (ld) chk(is_byt ? "R6/R3 byte load" : "R7 word load", ld_data, exp_ld);
  endtask

  initial begin
    for (int w = 0; w < 16; w++) ref_mem[w] = init_word(w);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset ld_valid", {31'd0, ld_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after reset", {31'd0, ld_valid}, 32'd0);
    // R5: word stores to every word, positive offsets
    for (int w = 0; w < 16; w++)
      issue(6'd43, 1'b1, 32'h100, 16'(16'h40 + 4*w), 32'h8C41_7A02 ^ (32'(w) << 13));
    // R1/R7: word loads through negative offsets
    for (int w = 0; w < 16; w++)
      issue(6'd35, 1'b1, 32'h200, 16'(-16'sd192 + 16'(4*w)), 32'h0);
    // R3/R6: every byte address, negative offsets
    for (int a = 0; a < 64; a++)
      issue(6'd32, 1'b1, 32'h180, 16'(a - 64), 32'h0);
    // R4: byte stores into words 2 and 3, then word readback
    for (int a = 8; a < 16; a++)
      issue(6'd40, 1'b1, 32'h140, 16'(a), 32'hFFFF_FF00 | 32'(8'h70 + a * 9));
    issue(6'd35, 1'b1, 32'h140, 16'd8, 32'h0);
    issue(6'd35, 1'b1, 32'h140, 16'd12, 32'h0);
    issue(6'd40, 1'b1, 32'h140, 16'd21, 32'h1234_56A5);
    issue(6'd35, 1'b1, 32'h140, 16'd20, 32'h0);
    // R8: misaligned word stores and loads do nothing
    for (int m = 1; m < 4; m++) begin
      issue(6'd43, 1'b1, 32'h140, 16'(24 + m), 32'hDEAD_BEEF);
      issue(6'd35, 1'b1, 32'h140, 16'(24 + m), 32'h0);
    end
    issue(6'd35, 1'b1, 32'h140, 16'd24, 32'h0);
    // R2: undefined codes and idle requests leave memory as it was
    issue(6'd0,  1'b1, 32'h140, 16'd28, 32'h1111_1111);
    issue(6'd36, 1'b1, 32'h140, 16'd28, 32'h2222_2222);
    issue(6'd41, 1'b1, 32'h140, 16'd29, 32'h3333_3333);
    issue(6'd43, 1'b0, 32'h140, 16'd28, 32'h4444_4444);
    issue(6'd35, 1'b1, 32'h140, 16'd28, 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule